// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address. It reads two levels of a page table from memory, one entry per level. A request carries the virtual address and an access-type bit. The walker samples the root table address, `root_base`, in the same cycle. It then fetches the level-one entry through a single-outstanding read port that uses a valid/ready request and a response valid. If that entry is valid, it fetches the level-two entry, and the frame number in that entry becomes the upper part of the physical address. The 12-bit page offset passes through unchanged. An entry whose valid bit is clear ends the walk at once with a fault, and no address is produced. A fault at level one also skips the level-two fetch, because such an entry covers a whole unallocated 4 MB region.

The control is one enumerated state machine with six states:
- `ST_IDLE` moves to `ST_FETCH_L1` when a request is accepted.
- `ST_FETCH_L1` moves to `ST_WAIT_L1` when the memory port accepts the fetch.
- `ST_WAIT_L1` moves to `ST_FETCH_L2` on a valid response, or to `ST_DONE` on an invalid one.
- `ST_FETCH_L2` moves to `ST_WAIT_L2` when the memory port accepts the fetch.
- `ST_WAIT_L2` moves to `ST_DONE` on any response.
- `ST_DONE` always returns to `ST_IDLE` one cycle later.

The memory may stall the request or delay the response by any number of cycles. The walker uses only the results it latched itself.

Top module: `pgw_walker`

## Requirements
- R1: After reset, `req_ready` is 1, and both `mem_req_valid` and `res_done` are 0.
- R2: A request is taken only while `req_ready` is high, which happens only in the idle state. `req_ready` drops the cycle after acceptance. While a walk is in progress, `req_valid` is ignored: it starts no fetch and does not change the result.
- R3: The first fetch address is `root_base + va[31:22]*4`, using `root_base` and `va` as sampled when the request was accepted.
- R4: The second fetch address is `{E1[31:12], 12'h000} + va[21:12]*4`, where E1 is the level-one entry.
- R5: An entry is valid when its bit 0 is 1. On a valid level-two entry E2, `res_fault` is 0, `res_pa` is `{E2[31:12], va[11:0]}` and `res_flags` is `E2[11:0]`.
- R6: If the level-one entry has bit 0 clear, the walk ends with `res_fault`=1 and `res_fault_lvl2`=0. Exactly one fetch is made, and `res_pa` and `res_flags` are 0, whatever the entry's upper bits hold.
- R7: If the level-two entry has bit 0 clear, the walk ends with `res_fault`=1 and `res_fault_lvl2`=1. Exactly two fetches are made, and `res_pa` and `res_flags` are 0.
- R8: `mem_req_valid` stays high, with `mem_req_addr` stable, until `mem_req_ready` is seen. The result does not depend on the request stall or on the response latency.
- R9: `res_done` is high for exactly one cycle per walk. `req_ready` is high again in the cycle after it.
- R10: `res_write` holds the access-type bit given with the request while `res_done` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| root_base | input | 32 | Address of the level-one table, sampled when a request is accepted |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle and able to take a request |
| req_va | input | 32 | Virtual address to translate |
| req_write | input | 1 | Access type: 1 for a write, 0 for a read |
| mem_req_valid | output | 1 | Entry fetch request |
| mem_req_ready | input | 1 | Memory takes the fetch request |
| mem_req_addr | output | 32 | Byte address of the entry to fetch |
| mem_rsp_valid | input | 1 | Fetched entry present on `mem_rsp_data` |
| mem_rsp_data | input | 32 | Fetched table entry |
| res_done | output | 1 | One-cycle pulse: result fields are valid |
| res_fault | output | 1 | Walk ended on an invalid entry |
| res_fault_lvl2 | output | 1 | The faulting entry was at level two |
| res_pa | output | 32 | Physical address, 0 on a fault |
| res_flags | output | 12 | Low 12 bits of the level-two entry, 0 on a fault |
| res_write | output | 1 | Access type of the finished request |

## Verification
The bound checker checks a set of rules on every cycle:
- the fetch request holds steady until it is accepted;
- the result pulse lasts one cycle, and `req_ready` drops after acceptance;
- both fetch addresses are correct against the sampled inputs and the first entry;
- the number of fetches matches the way the walk ended;
- a fault carries an all-zero address and flags;
- on success the offset is carried through, and the access type is echoed.

Some behaviours only the directed scenarios can show:
- the full physical address and flags taken from the memory image;
- behaviour at the extreme table indices;
- a request pressed during a walk having no effect;
- independence from the memory's ready and response timing.

// File: rtl/pgw_pkg.sv
package pgw_pkg;

    typedef enum logic [2:0] {
        ST_IDLE     = 3'd0,
        ST_FETCH_L1 = 3'd1,
        ST_WAIT_L1  = 3'd2,
        ST_FETCH_L2 = 3'd3,
        ST_WAIT_L2  = 3'd4,
        ST_DONE     = 3'd5
    } walk_state_t;

    localparam int unsigned WALK_LEVELS = 2;

endpackage

// File: rtl/pgw_entry_addr.sv
// Byte address of one table entry: table base plus index scaled by entry size.
module pgw_entry_addr #(
    parameter int ADDR_W = 32,
    parameter int IDX_W  = 10,
    parameter int SHIFT  = 2
) (
    input  logic [ADDR_W-1:0] tbl_base,
    input  logic [IDX_W-1:0]  idx,
    output logic [ADDR_W-1:0] entry_addr
);
    localparam int PAD_W = ADDR_W - IDX_W - SHIFT;

    assign entry_addr = tbl_base + {{PAD_W{1'b0}}, idx, {SHIFT{1'b0}}};
endmodule

// File: rtl/pgw_pte_decode.sv
// Splits a fetched table entry into valid bit, frame number and low flag bits.
module pgw_pte_decode #(
    parameter int PTE_W = 32,
    parameter int OFF_W = 12,
    parameter int PN_W  = 20
) (
    input  logic [PTE_W-1:0] pte,
    output logic             pte_valid,
    output logic [PN_W-1:0]  pte_frame,
    output logic [OFF_W-1:0] pte_flags
);
    assign pte_valid = pte[0];
    assign pte_frame = pte[OFF_W +: PN_W];
    assign pte_flags = pte[OFF_W-1:0];
endmodule

// File: rtl/pgw_walk_fsm.sv
// Walk sequencer: state register and next-state logic.
module pgw_walk_fsm
    import pgw_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_fire,
    input  logic        mem_fire,
    input  logic        rsp_valid,
    input  logic        pte_valid,
    output walk_state_t state
);
    walk_state_t state_nx;

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:     if (req_fire)  state_nx = ST_FETCH_L1;
            ST_FETCH_L1: if (mem_fire)  state_nx = ST_WAIT_L1;
            ST_WAIT_L1:  if (rsp_valid) state_nx = pte_valid ? ST_FETCH_L2 : ST_DONE;
            ST_FETCH_L2: if (mem_fire)  state_nx = ST_WAIT_L2;
            ST_WAIT_L2:  if (rsp_valid) state_nx = ST_DONE;
            ST_DONE:                    state_nx = ST_IDLE;
            default:                    state_nx = ST_IDLE;
        endcase
    end
endmodule

// File: rtl/pgw_walker.sv
// Two-level page table walker top.
module pgw_walker #(
    parameter int ADDR_W = 32,
    parameter int OFF_W  = 12,
    parameter int IDX_W  = 10,
    parameter int PTE_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] root_base,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_va,
    input  logic              req_write,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic [ADDR_W-1:0] mem_req_addr,
    input  logic              mem_rsp_valid,
    input  logic [PTE_W-1:0]  mem_rsp_data,
    output logic              res_done,
    output logic              res_fault,
    output logic              res_fault_lvl2,
    output logic [ADDR_W-1:0] res_pa,
    output logic [OFF_W-1:0]  res_flags,
    output logic              res_write
);
    import pgw_pkg::*;

    localparam int PN_W   = ADDR_W - OFF_W;
    localparam int SHIFT  = $clog2(PTE_W / 8);
    localparam int LEVELS = WALK_LEVELS;

    walk_state_t state;

    logic req_fire;
    logic mem_fire;
    assign req_fire = req_valid && req_ready;
    assign mem_fire = mem_req_valid && mem_req_ready;

    // Fetched-entry fields
    logic             pte_valid;
    logic [PN_W-1:0]  pte_frame;
    logic [OFF_W-1:0] pte_flags;

    pgw_pte_decode #(.PTE_W(PTE_W), .OFF_W(OFF_W), .PN_W(PN_W)) u_dec (
        .pte       (mem_rsp_data),
        .pte_valid (pte_valid),
        .pte_frame (pte_frame),
        .pte_flags (pte_flags)
    );

    pgw_walk_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_fire  (req_fire),
        .mem_fire  (mem_fire),
        .rsp_valid (mem_rsp_valid),
        .pte_valid (pte_valid),
        .state     (state)
    );

    // Walk context and result registers
    logic [ADDR_W-1:0] va_q;
    logic              wr_q;
    logic [ADDR_W-1:0] base_q;
    logic [ADDR_W-1:0] pa_q;
    logic [OFF_W-1:0]  flags_q;
    logic              fault_q;
    logic              lvl2_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            va_q    <= '0;
            wr_q    <= 1'b0;
            base_q  <= '0;
            pa_q    <= '0;
            flags_q <= '0;
            fault_q <= 1'b0;
            lvl2_q  <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (req_fire) begin
                        va_q    <= req_va;
                        wr_q    <= req_write;
                        base_q  <= root_base;
                        pa_q    <= '0;
                        flags_q <= '0;
                        fault_q <= 1'b0;
                        lvl2_q  <= 1'b0;
                    end
                end
                ST_WAIT_L1: begin
                    if (mem_rsp_valid) begin
                        if (pte_valid) begin
                            base_q <= {pte_frame, {OFF_W{1'b0}}};
                        end else begin
                            fault_q <= 1'b1;
                            lvl2_q  <= 1'b0;
                        end
                    end
                end
                ST_WAIT_L2: begin
                    if (mem_rsp_valid) begin
                        if (pte_valid) begin
                            pa_q    <= {pte_frame, va_q[OFF_W-1:0]};
                            flags_q <= pte_flags;
                        end else begin
                            fault_q <= 1'b1;
                            lvl2_q  <= 1'b1;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    // Entry addresses per level; the index field for level g sits above the
    // offset, most significant level first.
    logic [ADDR_W-1:0] lvl_addr [LEVELS];

    for (genvar g = 0; g < LEVELS; g++) begin : g_lvl
        pgw_entry_addr #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .SHIFT(SHIFT)) u_ea (
            .tbl_base   (base_q),
            .idx        (va_q[OFF_W + (LEVELS - 1 - g) * IDX_W +: IDX_W]),
            .entry_addr (lvl_addr[g])
        );
    end

    // Output process
    always_comb begin
        req_ready     = 1'b0;
        mem_req_valid = 1'b0;
        mem_req_addr  = '0;
        res_done      = 1'b0;
        unique case (state)
            ST_IDLE:     req_ready = 1'b1;
            ST_FETCH_L1: begin
                mem_req_valid = 1'b1;
                mem_req_addr  = lvl_addr[0];
            end
            ST_WAIT_L1:  ;
            ST_FETCH_L2: begin
                mem_req_valid = 1'b1;
                mem_req_addr  = lvl_addr[1];
            end
            ST_WAIT_L2:  ;
            ST_DONE:     res_done = 1'b1;
            default:     ;
        endcase
    end

    assign res_fault      = fault_q;
    assign res_fault_lvl2 = lvl2_q;
    assign res_pa         = pa_q;
    assign res_flags      = flags_q;
    assign res_write      = wr_q;

endmodule

// File: rtl/pgw_walker_chk.sv
// Port-level protocol and result checker, bound to the walker.
module pgw_walker_chk #(
    parameter int ADDR_W = 32,
    parameter int OFF_W  = 12,
    parameter int IDX_W  = 10,
    parameter int PTE_W  = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] root_base,
    input logic              req_valid,
    input logic              req_ready,
    input logic [ADDR_W-1:0] req_va,
    input logic              req_write,
    input logic              mem_req_valid,
    input logic              mem_req_ready,
    input logic [ADDR_W-1:0] mem_req_addr,
    input logic              mem_rsp_valid,
    input logic [PTE_W-1:0]  mem_rsp_data,
    input logic              res_done,
    input logic              res_fault,
    input logic              res_fault_lvl2,
    input logic [ADDR_W-1:0] res_pa,
    input logic [OFF_W-1:0]  res_flags,
    input logic              res_write
);
    localparam int SHIFT = $clog2(PTE_W / 8);
    localparam int PAD_W = ADDR_W - IDX_W - SHIFT;

    logic [ADDR_W-1:0] va_cap;
    logic [ADDR_W-1:0] root_cap;
    logic              wr_cap;
    logic [ADDR_W-1:0] l1_base;
    logic [1:0]        fetch_cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            va_cap    <= '0;
            root_cap  <= '0;
            wr_cap    <= 1'b0;
            l1_base   <= '0;
            fetch_cnt <= '0;
        end else begin
            if (req_valid && req_ready) begin
                va_cap    <= req_va;
                root_cap  <= root_base;
                wr_cap    <= req_write;
                fetch_cnt <= '0;
            end else if (mem_req_valid && mem_req_ready && fetch_cnt != 2'd3) begin
                fetch_cnt <= fetch_cnt + 2'd1;
            end
            if (mem_rsp_valid && fetch_cnt == 2'd1)
                l1_base <= {mem_rsp_data[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
        end
    end

    logic [ADDR_W-1:0] exp_a1;
    logic [ADDR_W-1:0] exp_a2;
    assign exp_a1 = root_cap + {{PAD_W{1'b0}}, va_cap[ADDR_W-1 -: IDX_W], {SHIFT{1'b0}}};
    assign exp_a2 = l1_base  + {{PAD_W{1'b0}}, va_cap[OFF_W +: IDX_W], {SHIFT{1'b0}}};

    assert_ready_drop_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    assert_l1_addr_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && fetch_cnt == 2'd0) |-> mem_req_addr == exp_a1);

    assert_l2_addr_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && fetch_cnt == 2'd1) |-> mem_req_addr == exp_a2);

    assert_offset_pass_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (res_done && !res_fault) |-> res_pa[OFF_W-1:0] == va_cap[OFF_W-1:0]);

    assert_l1_fault_one_fetch_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (res_done && res_fault && !res_fault_lvl2) |-> fetch_cnt == 2'd1);

    assert_fault_zero_pa_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (res_done && res_fault) |-> (res_pa == '0 && res_flags == '0));

    assert_two_fetches_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (res_done && (!res_fault || res_fault_lvl2)) |-> fetch_cnt == 2'd2);

    assert_req_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        res_done |=> (!res_done && req_ready));

    assert_write_echo_R10: assert property (@(posedge clk) disable iff (!rst_n)
        res_done |-> res_write == wr_cap);

endmodule

bind pgw_walker pgw_walker_chk #(
    .ADDR_W (ADDR_W),
    .OFF_W  (OFF_W),
    .IDX_W  (IDX_W),
    .PTE_W  (PTE_W)
) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .root_base      (root_base),
    .req_valid      (req_valid),
    .req_ready      (req_ready),
    .req_va         (req_va),
    .req_write      (req_write),
    .mem_req_valid  (mem_req_valid),
    .mem_req_ready  (mem_req_ready),
    .mem_req_addr   (mem_req_addr),
    .mem_rsp_valid  (mem_rsp_valid),
    .mem_rsp_data   (mem_rsp_data),
    .res_done       (res_done),
    .res_fault      (res_fault),
    .res_fault_lvl2 (res_fault_lvl2),
    .res_pa         (res_pa),
    .res_flags      (res_flags),
    .res_write      (res_write)
);

// File: tb/pgw_walker_test.sv
module pgw_walker_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] root_base = '0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_va = '0;
    logic        req_write = 1'b0;
    logic        mem_req_valid;
    logic        mem_req_ready = 1'b0;
    logic [31:0] mem_req_addr;
    logic        mem_rsp_valid = 1'b0;
    logic [31:0] mem_rsp_data = '0;
    logic        res_done;
    logic        res_fault;
    logic        res_fault_lvl2;
    logic [31:0] res_pa;
    logic [11:0] res_flags;
    logic        res_write;

    pgw_walker uut (
        .clk(clk), .rst_n(rst_n), .root_base(root_base),
        .req_valid(req_valid), .req_ready(req_ready), .req_va(req_va), .req_write(req_write),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
        .res_done(res_done), .res_fault(res_fault), .res_fault_lvl2(res_fault_lvl2),
        .res_pa(res_pa), .res_flags(res_flags), .res_write(res_write)
    );

    always #4 clk = ~clk;   // 125 MHz

    int n_checks = 0;
    int n_fail   = 0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // ---------------- memory model ----------------
    logic [31:0] mem_img [logic [31:0]];
    logic [31:0] fetch_log [int];
    int          fetch_total = 0;
    int          cfg_lat = 0;
    int          cfg_rdy = 0;
    int          hs_count = 0;
    logic [31:0] hs_addr = '0;
    int          hs_done = 0;
    bit          pend = 0;
    int          lat_cnt = 0;
    int          rdy_cnt = 0;
    logic [31:0] pend_addr = '0;

    function automatic logic [31:0] rd(input logic [31:0] a);
        if (mem_img.exists(a)) return mem_img[a];
        return 32'h0;
    endfunction

    always @(posedge clk) begin
        if (rst_n && mem_req_valid && mem_req_ready) begin
            hs_count <= hs_count + 1;
            hs_addr  <= mem_req_addr;
        end
    end

    always @(negedge clk) begin
        mem_rsp_valid = 1'b0;
        if (hs_count != hs_done) begin
            hs_done = hs_count;
            pend = 1;
            lat_cnt = cfg_lat;
            pend_addr = hs_addr;
            fetch_log[fetch_total] = hs_addr;
            fetch_total++;
        end
        if (pend) begin
            if (lat_cnt == 0) begin
                mem_rsp_valid = 1'b1;
                mem_rsp_data  = rd(pend_addr);
                pend = 0;
            end else begin
                lat_cnt--;
            end
        end
        if (!pend && mem_req_valid && hs_count == hs_done) begin
            if (rdy_cnt >= cfg_rdy) mem_req_ready = 1'b1;
            else begin
                rdy_cnt++;
                mem_req_ready = 1'b0;
            end
        end else begin
            mem_req_ready = 1'b0;
            rdy_cnt = 0;
        end
    end

    // ---------------- walk driver ----------------
    logic [31:0] o_pa;
    logic [11:0] o_flags;
    logic        o_fault, o_lvl2, o_wr;
    int          o_fetches;
    int          o_first;

    task automatic do_walk(input logic [31:0] va, input logic wr, input logic [31:0] root,
                           input int rdy, input int lat);
        int waited;
        cfg_rdy = rdy;
        cfg_lat = lat;
        o_first = fetch_total;
        @(negedge clk);
        req_valid = 1'b1;
        req_va    = va;
        req_write = wr;
        root_base = root;
        @(negedge clk);
        req_valid = 1'b0;
        req_va    = 32'h5A5A_5A5A;
        req_write = ~wr;
        root_base = 32'hFFFF_0000;
        waited = 0;
        while (!res_done && waited < 500) begin
            @(negedge clk);
            waited++;
        end
        chk("R9 done seen", {31'b0, res_done}, 32'h1);
        o_pa      = res_pa;
        o_flags   = res_flags;
        o_fault   = res_fault;
        o_lvl2    = res_fault_lvl2;
        o_wr      = res_write;
        o_fetches = fetch_total - o_first;
        @(negedge clk);
        chk("R9 done one cycle", {31'b0, res_done}, 32'h0);
        chk("R9 ready after done", {31'b0, req_ready}, 32'h1);
    endtask

    // ---------------- scenarios ----------------
    localparam logic [31:0] ROOT = 32'h0001_0000;

    task automatic t_reset;
        chk("R1 req_ready", {31'b0, req_ready}, 32'h1);
        chk("R1 mem_req_valid", {31'b0, mem_req_valid}, 32'h0);
        chk("R1 res_done", {31'b0, res_done}, 32'h0);
    endtask

    task automatic t_hit_basic;
        do_walk(32'h0040_3ABC, 1'b0, ROOT, 0, 0);
        chk("R3 first fetch addr", fetch_log[o_first], 32'h0001_0004);
        chk("R4 second fetch addr", fetch_log[o_first + 1], 32'h0002_000C);
        chk("R5 fault", {31'b0, o_fault}, 32'h0);
        chk("R5 pa", o_pa, 32'h0ABC_DABC);
        chk("R5 flags", {20'b0, o_flags}, 32'h0000_0067);
        chk("R10 write echo read", {31'b0, o_wr}, 32'h0);
    endtask

    task automatic t_slow_mem;
        do_walk(32'h0040_3ABC, 1'b1, ROOT, 3, 5);
        chk("R8 pa with stalls", o_pa, 32'h0ABC_DABC);
        chk("R8 flags with stalls", {20'b0, o_flags}, 32'h0000_0067);
        chk("R8 fetch count", o_fetches, 2);
        chk("R10 write echo write", {31'b0, o_wr}, 32'h1);
    endtask

    task automatic t_l1_fault;
        do_walk(32'h0080_0123, 1'b0, ROOT, 1, 2);
        chk("R6 fault", {31'b0, o_fault}, 32'h1);
        chk("R6 level", {31'b0, o_lvl2}, 32'h0);
        chk("R6 fetches", o_fetches, 1);
        chk("R6 pa zero", o_pa, 32'h0);
        // invalid level-one entry whose upper bits are nonzero
        do_walk(32'h0100_0000, 1'b0, ROOT, 0, 0);
        chk("R6 fault nonzero frame", {31'b0, o_fault}, 32'h1);
        chk("R6 fetches nonzero frame", o_fetches, 1);
        chk("R6 flags zero", {20'b0, o_flags}, 32'h0);
    endtask

    task automatic t_l2_fault;
        do_walk(32'h0040_5000, 1'b0, ROOT, 0, 3);
        chk("R7 fault", {31'b0, o_fault}, 32'h1);
        chk("R7 level", {31'b0, o_lvl2}, 32'h1);
        chk("R7 fetches", o_fetches, 2);
        chk("R7 pa zero", o_pa, 32'h0);
    endtask

    task automatic t_edge_indices;
        do_walk(32'hFFFF_FFFF, 1'b0, ROOT, 0, 0);
        chk("R3 max index addr", fetch_log[o_first], 32'h0001_0FFC);
        chk("R4 max index addr", fetch_log[o_first + 1], 32'h0003_0FFC);
        chk("R5 max pa", o_pa, 32'hFFFF_FFFF);
        do_walk(32'h0000_0000, 1'b0, ROOT, 2, 1);
        chk("R3 zero index addr", fetch_log[o_first], 32'h0001_0000);
        chk("R4 zero index addr", fetch_log[o_first + 1], 32'h0004_0000);
        chk("R5 zero va pa", o_pa, 32'h0000_5000);
        chk("R5 zero va flags", {20'b0, o_flags}, 32'h0000_00F3);
    endtask

    task automatic t_busy_ignore;
        int waited;
        int busy_ready;
        int first;
        int after;
        bit extra_done;
        cfg_rdy = 2;
        cfg_lat = 4;
        first = fetch_total;
        busy_ready = 0;
        @(negedge clk);
        req_valid = 1'b1;
        req_va    = 32'h0040_3ABC;
        req_write = 1'b0;
        root_base = ROOT;
        @(negedge clk);
        req_va    = 32'hFFFF_FFFF;   // different request held during the walk
        root_base = 32'h0002_0000;
        waited = 0;
        while (!res_done && waited < 500) begin
            if (req_ready) busy_ready++;
            @(negedge clk);
            waited++;
        end
        req_valid = 1'b0;
        chk("R2 no ready while busy", busy_ready, 0);
        chk("R2 result of first request", res_pa, 32'h0ABC_DABC);
        chk("R2 fetches during walk", fetch_total - first, 2);
        after = fetch_total;
        extra_done = 0;
        repeat (10) begin
            @(negedge clk);
            if (res_done) extra_done = 1;
        end
        chk("R2 no extra fetch", fetch_total - after, 0);
        chk("R2 no extra done", {31'b0, extra_done}, 32'h0);
    endtask

    // ---------------- main ----------------
    bit finished = 0;

    initial begin
        mem_img[32'h0001_0004] = 32'h0002_0001;
        mem_img[32'h0002_000C] = 32'h0ABC_D067;
        mem_img[32'h0001_0010] = 32'h0002_0000;   // invalid, nonzero frame
        mem_img[32'h0001_0FFC] = 32'h0003_0001;
        mem_img[32'h0003_0FFC] = 32'hFFFF_F001;
        mem_img[32'h0001_0000] = 32'h0004_0001;
        mem_img[32'h0004_0000] = 32'h0000_50F3;

        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_hit_basic();
        t_slow_mem();
        t_l1_fault();
        t_l2_fault();
        t_edge_indices();
        t_busy_ignore();
        repeat (3) @(negedge clk);
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog R1-all actual=hung expected=completed");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule